// File: doc/BRIEF.md
# Tagged Direct-Mapped Overflow Store

This block sits between a client and a large, slow backing memory. It keeps a small direct-mapped local array. Each slot of that array holds one data word, the upper address bits of the word it owns, and an occupancy flag. The client sees a single-port read/write interface with a ready/valid request handshake and a one-cycle response pulse. Accesses the local array can serve finish one cycle after acceptance. All other accesses go out on a request/acknowledge backing port, and the client stalls until the backing side answers.

Slots are never replaced. The first write that lands on a free slot takes ownership of it for good. Later writes to that same address update the slot in place. Every other address that maps to the slot is sent to the backing port from then on. Reads that find a free slot, or a slot owned by a different address, are sent to the backing port as well. The result is that each address has exactly one home.

The local depth is a power-of-two parameter that does not depend on the address width. The low address bits select the slot and the remaining upper bits form the stored tag. After reset the block sweeps every slot to free before it accepts any request. It also reports a per-access local/forwarded pulse and the number of owned slots.

Top module: `tagged_overflow_store`

## Requirements
- R1: After reset is released, `req_ready` stays low for DEPTH+2 clock cycles: two for reset synchronisation and DEPTH for the slot sweep. It then goes high with `occupied` at 0. During this time `bk_req` and `rsp_valid` stay low.
- R2: The slot index is `req_addr[IDX_W-1:0]` with IDX_W = log2(DEPTH), and the tag is the remaining upper bits. Addresses that share an index but differ in tag never both live locally. Addresses at index 0 and at index DEPTH-1 behave the same as any other index.
- R3: A write accepted on a free slot claims it with no backing access. One cycle after acceptance, `rsp_valid` and `hit` are high and `occupied` has risen by one.
- R4: A read whose slot is owned by the same tag returns the local word on `rsp_rdata`, with `rsp_valid` and `hit` high one cycle after acceptance, and raises no `bk_req`.
- R5: A read whose slot is free, or is owned by another tag, raises `bk_req` with `bk_we`=0 and the full address. The cycle after `bk_ack` is sampled, `rsp_valid` is high and `rsp_rdata` equals the `bk_rdata` presented with the acknowledge.
- R6: A write whose slot is owned by another tag goes to the backing port with its address and data (`bk_we`=1). The owning slot keeps its tag and its data.
- R7: A write whose slot is owned by the same tag replaces the local word with no backing access. `occupied` does not change.
- R8: Only one backing request is outstanding at a time. From acceptance of a forwarded access until `bk_ack` is sampled, `req_ready` is low and `bk_req`, `bk_we`, `bk_addr` and `bk_wdata` hold steady.
- R9: Each accepted access gives exactly one one-cycle pulse, on `hit` if it was served locally or on `miss` if it was forwarded, one cycle after acceptance. `occupied` only increases, by one per claim, and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Full word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, meaningful with rsp_valid for reads |
| bk_req | output | 1 | Backing request held until acknowledged |
| bk_we | output | 1 | Backing request is a write |
| bk_addr | output | ADDR_W | Backing address |
| bk_wdata | output | DATA_W | Backing write data |
| bk_ack | input | 1 | Backing side completes the request (one cycle) |
| bk_rdata | input | DATA_W | Backing read data, valid with bk_ack |
| hit | output | 1 | Access served locally (pulse) |
| miss | output | 1 | Access forwarded to backing (pulse) |
| occupied | output | $clog2(DEPTH+1) | Number of owned slots |

## Verification
Suppose a slot held a wrong owner, a stale valid bit or a wrong word. The next access to that index would show it on the ports within one cycle of acceptance, as a hit or miss pulse with the wrong polarity, a backing request that appears or is missing, or read data that differs from the last value written to that address. A sweep that was cut short, or a counter that drifted, would show up in `occupied` right after the claim that exposes it. A lost acknowledge would leave `req_ready` low for good. The bench therefore keeps its own ownership map and word map and compares every access on the cycle it completes, using address pools small enough to force many index conflicts.

// File: rtl/tos_pkg.sv
package tos_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_WAIT  = 2'd2
  } tos_state_e;

  typedef enum logic [1:0] {
    ACT_CLAIM    = 2'd0,
    ACT_UPDATE   = 2'd1,
    ACT_RD_LOCAL = 2'd2,
    ACT_FORWARD  = 2'd3
  } tos_act_e;
endpackage

// File: rtl/tos_rst_sync.sv
module tos_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tos_slot_array.sv
module tos_slot_array #(
  parameter  int DEPTH  = 64,
  parameter  int TAG_W  = 10,
  parameter  int DATA_W = 32,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [DATA_W-1:0] lk_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DEPTH-1:0]  valid_vec;
  logic [TAG_W-1:0]  tag_arr  [DEPTH];
  logic [DATA_W-1:0] data_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              v_q, v_d;
    logic [TAG_W-1:0]  t_q, t_d;
    logic [DATA_W-1:0] d_q, d_d;
    logic              sel_wr, sel_clr;

    assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(g));
    assign sel_clr = clr_en && (clr_idx == IDX_W'(g));

    always_comb begin
      v_d = v_q;
      t_d = t_q;
      d_d = d_q;
      if (sel_clr) begin
        v_d = 1'b0;
      end else if (sel_wr) begin
        v_d = 1'b1;
        t_d = wr_tag;
        d_d = wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_clr || sel_wr) begin
        v_q <= v_d;
        t_q <= t_d;
        d_q <= d_d;
      end
    end

    assign valid_vec[g] = v_q;
    assign tag_arr[g]   = t_q;
    assign data_arr[g]  = d_q;
  end

  assign lk_valid = valid_vec[lk_idx];
  assign lk_tag   = tag_arr[lk_idx];
  assign lk_data  = data_arr[lk_idx];
endmodule

// File: rtl/tos_occ_count.sv
module tos_occ_count #(
  parameter  int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                                cnt_d = '0;
    else if (inc && cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tos_ctrl.sv
module tos_ctrl
  import tos_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 64,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic              claim,
  output logic              bk_req,
  output logic              bk_we,
  output logic [ADDR_W-1:0] bk_addr,
  output logic [DATA_W-1:0] bk_wdata,
  input  logic              bk_ack,
  input  logic [DATA_W-1:0] bk_rdata,
  output logic              hit,
  output logic              miss
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  tos_state_e        state_q, state_d;
  tos_act_e          act;
  logic [IDX_W-1:0]  sweep_q, sweep_d;
  logic              rsp_valid_q, rsp_valid_d;
  logic              hit_q, hit_d, miss_q, miss_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic              rsp_data_en;
  logic              bk_we_q;
  logic [ADDR_W-1:0] bk_addr_q;
  logic [DATA_W-1:0] bk_wdata_q;
  logic              bk_load;
  logic [TAG_W-1:0]  req_tag;
  logic              accept, tag_eq, served_local;

  assign req_tag   = req_addr[ADDR_W-1:IDX_W];
  assign lk_idx    = req_addr[IDX_W-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign tag_eq    = lk_valid && (lk_tag == req_tag);

  // Per-access decision: slots are claimed once and never replaced
  always_comb begin
    if (req_we) begin
      if (!lk_valid)   act = ACT_CLAIM;
      else if (tag_eq) act = ACT_UPDATE;
      else             act = ACT_FORWARD;
    end else begin
      act = tag_eq ? ACT_RD_LOCAL : ACT_FORWARD;
    end
  end

  assign served_local = (act != ACT_FORWARD);

  assign wr_en   = accept && (act == ACT_CLAIM || act == ACT_UPDATE);
  assign wr_idx  = lk_idx;
  assign wr_tag  = req_tag;
  assign wr_data = req_wdata;
  assign claim   = accept && (act == ACT_CLAIM);
  assign clr_en  = (state_q == ST_CLEAR);
  assign clr_idx = sweep_q;

  always_comb begin
    state_d     = state_q;
    sweep_d     = sweep_q;
    rsp_valid_d = 1'b0;
    hit_d       = 1'b0;
    miss_d      = 1'b0;
    rsp_data_d  = rsp_data_q;
    rsp_data_en = 1'b0;
    bk_load     = 1'b0;
    case (state_q)
      ST_CLEAR: begin
        sweep_d = sweep_q + 1'b1;
        if (sweep_q == LAST_IDX) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (accept) begin
          hit_d  = served_local;
          miss_d = !served_local;
          if (served_local) begin
            rsp_valid_d = 1'b1;
            if (act == ACT_RD_LOCAL) begin
              rsp_data_d  = lk_data;
              rsp_data_en = 1'b1;
            end
          end else begin
            bk_load = 1'b1;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (bk_ack) begin
          state_d     = ST_IDLE;
          rsp_valid_d = 1'b1;
          if (!bk_we_q) begin
            rsp_data_d  = bk_rdata;
            rsp_data_en = 1'b1;
          end
        end
      end
      default: state_d = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_CLEAR;
      sweep_q     <= '0;
      rsp_valid_q <= 1'b0;
      hit_q       <= 1'b0;
      miss_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      sweep_q     <= sweep_d;
      rsp_valid_q <= rsp_valid_d;
      hit_q       <= hit_d;
      miss_q      <= miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_data_en) rsp_data_q <= rsp_data_d;
    if (bk_load) begin
      bk_we_q    <= req_we;
      bk_addr_q  <= req_addr;
      bk_wdata_q <= req_wdata;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign hit       = hit_q;
  assign miss      = miss_q;
  assign bk_req    = (state_q == ST_WAIT);
  assign bk_we     = bk_we_q;
  assign bk_addr   = bk_addr_q;
  assign bk_wdata  = bk_wdata_q;
endmodule

// File: rtl/tagged_overflow_store.sv
module tagged_overflow_store #(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 64,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bk_req,
  output logic              bk_we,
  output logic [ADDR_W-1:0] bk_addr,
  output logic [DATA_W-1:0] bk_wdata,
  input  logic              bk_ack,
  input  logic [DATA_W-1:0] bk_rdata,
  output logic              hit,
  output logic              miss,
  output logic [CNT_W-1:0]  occupied
);
  logic              rst_n_int;
  logic [IDX_W-1:0]  lk_idx, clr_idx, wr_idx;
  logic              lk_valid, clr_en, wr_en, claim;
  logic [TAG_W-1:0]  lk_tag, wr_tag;
  logic [DATA_W-1:0] lk_data, wr_data;

  tos_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tos_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .lk_idx    (lk_idx),
    .lk_valid  (lk_valid),
    .lk_tag    (lk_tag),
    .lk_data   (lk_data),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_tag    (wr_tag),
    .wr_data   (wr_data),
    .claim     (claim),
    .bk_req    (bk_req),
    .bk_we     (bk_we),
    .bk_addr   (bk_addr),
    .bk_wdata  (bk_wdata),
    .bk_ack    (bk_ack),
    .bk_rdata  (bk_rdata),
    .hit       (hit),
    .miss      (miss)
  );

  tos_slot_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slots (
    .clk      (clk),
    .lk_idx   (lk_idx),
    .lk_valid (lk_valid),
    .lk_tag   (lk_tag),
    .lk_data  (lk_data),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data)
  );

  tos_occ_count #(.DEPTH(DEPTH)) u_occ (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (clr_en),
    .inc   (claim),
    .count (occupied)
  );
endmodule

// File: rtl/tos_checker.sv
module tos_checker #(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 64,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bk_req,
  input logic              bk_we,
  input logic [ADDR_W-1:0] bk_addr,
  input logic [DATA_W-1:0] bk_wdata,
  input logic              bk_ack,
  input logic              hit,
  input logic              miss,
  input logic [CNT_W-1:0]  occupied
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(hit && miss)); // R9
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) occupied <= CNT_W'(DEPTH)); // R9
  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (occupied == $past(occupied)) || (occupied == $past(occupied) + 1'b1)); // R9
  AST_CLAIM_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n) (occupied != $past(occupied)) |-> hit); // R3
  AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n) hit |-> rsp_valid); // R4
  AST_NO_READY_WAIT: assert property (@(posedge clk) disable iff (!rst_n) bk_req |-> !req_ready); // R8
  AST_BK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bk_req && !bk_ack) |=> (bk_req && $stable(bk_we) && $stable(bk_addr) && $stable(bk_wdata))); // R8
  AST_ACK_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n) (bk_req && bk_ack) |=> (rsp_valid && !bk_req)); // R5
endmodule

bind tagged_overflow_store tos_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bk_req    (bk_req),
  .bk_we     (bk_we),
  .bk_addr   (bk_addr),
  .bk_wdata  (bk_wdata),
  .bk_ack    (bk_ack),
  .hit       (hit),
  .miss      (miss),
  .occupied  (occupied)
);

// File: tb/tb_tagged_overflow_store.sv
`timescale 1ns/1ps
module tb_tagged_overflow_store;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_ready, req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              bk_req, bk_we, bk_ack;
  logic [ADDR_W-1:0] bk_addr;
  logic [DATA_W-1:0] bk_wdata, bk_rdata;
  logic              hit, miss;
  logic [CNT_W-1:0]  occupied;

  always #5 clk = ~clk;

  tagged_overflow_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bk_req(bk_req), .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata),
    .bk_ack(bk_ack), .bk_rdata(bk_rdata),
    .hit(hit), .miss(miss), .occupied(occupied)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Bench reference state
  bit              own_v   [DEPTH];
  bit [TAG_W-1:0]  own_tag [DEPTH];
  bit [DATA_W-1:0] golden  [int];
  bit [DATA_W-1:0] backing [int];
  int              occ_model = 0;

  // Backing responder bookkeeping
  int              bk_ops = 0;
  bit              last_we;
  bit [ADDR_W-1:0] last_addr;
  bit [DATA_W-1:0] last_wdata;
  bit              hold_ok = 1;
  bit              seen_req = 0;
  bit [ADDR_W-1:0] cap_addr;
  int              wait_cnt = 0;

  function automatic bit [DATA_W-1:0] dflt_word(input bit [ADDR_W-1:0] a);
    return {a, a ^ 16'hA5C3};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Backing memory model with variable latency, acts at negedges
  initial begin
    bk_ack = 1'b0;
    bk_rdata = '0;
    forever begin
      @(negedge clk);
      if (bk_ack) begin
        bk_ack = 1'b0;
        seen_req = 0;
      end else if (bk_req) begin
        if (!seen_req) begin
          seen_req = 1;
          cap_addr = bk_addr;
        end else if (bk_addr != cap_addr) begin
          hold_ok = 0;
        end
        if (wait_cnt == 0) begin
          last_we    = bk_we;
          last_addr  = bk_addr;
          last_wdata = bk_wdata;
          if (bk_we) backing[int'(bk_addr)] = bk_wdata;
          else bk_rdata = backing.exists(int'(bk_addr)) ? backing[int'(bk_addr)] : dflt_word(bk_addr);
          bk_ops++;
          bk_ack = 1'b1;
          wait_cnt = $urandom % 4;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic access(input bit we, input bit [ADDR_W-1:0] addr,
                        input bit [DATA_W-1:0] wd, input string rq);
    bit [IDX_W-1:0]  idx;
    bit [TAG_W-1:0]  tg;
    bit              loc;
    bit [DATA_W-1:0] exp_rd;
    int              ops0, n;
    idx  = addr[IDX_W-1:0];
    tg   = addr[ADDR_W-1:IDX_W];
    loc  = we ? (!own_v[idx] || own_tag[idx] == tg) : (own_v[idx] && own_tag[idx] == tg);
    exp_rd = golden.exists(int'(addr)) ? golden[int'(addr)] : dflt_word(addr);
    ops0 = bk_ops;
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(hit == loc && miss == !loc, "R9", {rq, " hit/miss pulse"}, {hit, miss}, {loc, !loc});
    if (loc) begin
      chk(rsp_valid && !bk_req, rq, "local response one cycle after accept", {rsp_valid, bk_req}, 2'b10);
      if (!we) chk(rsp_rdata == exp_rd, "R4", "local read data", rsp_rdata, exp_rd);
    end else begin
      chk(bk_req && !req_ready && !rsp_valid, "R8", "stall while forwarded", {bk_req, req_ready, rsp_valid}, 3'b100);
      n = 0;
      while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
      chk(rsp_valid, rq, "forwarded response", rsp_valid, 1);
      if (!we) chk(rsp_rdata == exp_rd, "R5", "backing read data", rsp_rdata, exp_rd);
      chk(last_addr == addr && last_we == we, rq, "backing address/op", {last_we, last_addr}, {we, addr});
      if (we) chk(last_wdata == wd, "R6", "backing write data", last_wdata, wd);
      chk(hold_ok, "R8", "backing request held steady", hold_ok, 1);
    end
    chk(bk_ops == ops0 + (loc ? 0 : 1), rq, "backing op count", bk_ops, ops0 + (loc ? 0 : 1));
    if (we) begin
      golden[int'(addr)] = wd;
      if (loc && !own_v[idx]) begin
        own_v[idx] = 1; own_tag[idx] = tg; occ_model++;
      end
    end
    chk(occupied == CNT_W'(occ_model), "R9", {rq, " occupancy"}, occupied, occ_model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240917));
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!req_ready && !bk_req && !rsp_valid && occupied == 0, "R1", "reset state",
        {req_ready, bk_req, rsp_valid}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 1000) begin
      @(negedge clk);
      n++;
      if (bk_req || rsp_valid) chk(0, "R1", "activity during sweep", {bk_req, rsp_valid}, 0);
    end
    chk(n == DEPTH + 2, "R1", "cycles until ready", n, DEPTH + 2);
    chk(occupied == 0, "R1", "occupancy after sweep", occupied, 0);

    // Directed corner cases (index 0 shared by tags 1 and 2)
    access(0, 16'h0040, 0, "R5");              // read of free slot
    access(1, 16'h0040, 32'h1111_1111, "R3");  // claim
    access(0, 16'h0040, 0, "R4");              // hit
    access(1, 16'h0040, 32'h2222_2222, "R7");  // in-place update
    access(1, 16'h0080, 32'h3333_3333, "R6");  // conflicting write
    access(0, 16'h0040, 0, "R6");              // owner keeps its word
    access(0, 16'h0080, 0, "R5");              // conflicting read from backing
    access(1, 16'hFFFF, 32'hABCD_0001, "R2");  // top index, top tag
    access(0, 16'hFFFF, 0, "R2");
    access(0, 16'h003F, 0, "R2");              // same index, tag 0: forwarded
    access(1, 16'h0000, 32'h0BAD_F00D, "R2");  // index 0 with tag 0: conflict
    access(0, 16'h0000, 0, "R2");

    // Constrained random traffic over a few tags per index to force conflicts
    for (int i = 0; i < 600; i++) begin
      bit [TAG_W-1:0] t;
      bit [IDX_W-1:0] x;
      bit w;
      t = TAG_W'($urandom % 4);
      x = IDX_W'($urandom);
      w = ($urandom % 2) == 0;
      access(w, {t, x}, $urandom, w ? "R3" : "R4");
    end
    chk(occupied <= CNT_W'(DEPTH), "R9", "occupancy bound", occupied, DEPTH);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule